// File: doc/BRIEF.md
# SPI-Loaded Serial LED Strip Driver

This block lets a host processor light a chain of single-wire addressable RGB LEDs without any real-time code of its own. The host shifts colour bytes in over an SPI slave port. Every three bytes form one 24-bit pixel, and that pixel is written to the next free slot of an on-chip buffer. Once the frame is loaded, the host raises a separate SYNC line. The block then plays the stored pixels out back to back as a self-timed pulse-width stream, holds the line low for the latch gap, and drops its busy flag.

Every pulse width is computed at elaboration from the system clock frequency parameter. Moving to another clock needs only a new parameter value. The buffer depth comes from an address-width parameter: 1024 pixels by default, and a wider address reaches several thousand LEDs. The SPI port has no back-pressure. While busy is high, incoming bytes and SYNC edges are simply discarded, so the host must wait for busy to fall before it loads the next frame.

Top module: `ledstrip_spi_driver`

## Requirements
- R1: SPI runs in mode 0: MOSI is sampled on rising SCK edges while the active-low chip select is low, and bytes arrive MSB first. Chip select going high discards any partly received byte and any partly assembled pixel.
- R2: Three consecutive accepted bytes form one pixel. The first byte (green) lands in bits 23:16, the second (red) in bits 15:8 and the third (blue) in bits 7:0. The pixel is stored at the current write address, which then advances by one.
- R3: On transmission, pixels leave in the order they were written, each sent bit 23 first and bit 0 last.
- R4: A 0 bit is a high of round(400 ns) followed by a low of round(850 ns). A 1 bit is a high of round(800 ns) followed by a low of round(450 ns), each rounded to whole clock cycles. Bits and pixels follow one another with no added cycles.
- R5: After the last bit's low period, the output stays low for round(50 us) more cycles. Busy falls exactly when that gap ends.
- R6: A rising edge on SYNC while idle captures the number of pixels loaded as the frame length, rewinds the read address to 0, raises busy and starts the stream.
- R7: SPI bytes and SYNC rising edges that arrive while busy is high are discarded and change nothing.
- R8: When busy falls, the write address returns to 0, so the next frame loads from the first slot.
- R9: A SYNC edge with no pixels loaded produces no high pulse, only the latch gap with busy high.
- R10: Once the buffer holds 2^ADDR_W pixels, further pixels are dropped until the write address is cleared.
- R11: A pixel whose final SCK rising edge arrives in the same clock cycle as the SYNC rising edge belongs to the frame that this SYNC edge starts.
- R12: After reset the data output and busy are low and the buffer counts as empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pulse timing derives from CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock from the host (mode 0) |
| spi_mosi | input | 1 | SPI data from the host, MSB first |
| spi_cs_n | input | 1 | SPI chip select, active low |
| sync_in | input | 1 | Frame-show request; a rising edge starts the stream |
| led_dout | output | 1 | Single-wire pulse stream to the LED chain |
| busy | output | 1 | High from an accepted SYNC edge until the latch gap ends |

## Verification
Two functions can meet in one clock cycle: the write of a freshly completed pixel, and the capture of the frame length on a SYNC edge. The bench provokes this by raising SYNC at the same instant as the 24th SCK rising edge of the final pixel. Both edges therefore pass through synchronizers of equal depth. The result is judged at the data output alone: that last pixel has to appear as the final 24 bits of the frame, with correct pulse widths and the latch gap after it.

// File: rtl/ledstrip_pkg.sv
package ledstrip_pkg;

  localparam int PIX_W = 24;

  typedef logic [PIX_W-1:0] pixel_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_SEND,
    ST_LATCH
  } tx_state_e;

  // nanoseconds to whole clock cycles, rounded to nearest
  function automatic int ns_to_cycles(longint clk_hz, longint ns);
    longint c;
    c = (clk_hz * ns + 64'sd500_000_000) / 64'sd1_000_000_000;
    return int'(c);
  endfunction

endpackage

// File: rtl/led_spi_rx.sv
module led_spi_rx #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sck,
  input  logic       spi_mosi,
  input  logic       spi_cs_n,
  output logic       byte_vld,
  output logic [7:0] byte_data,
  output logic       cs_idle
);

  logic [SYNC_STAGES-1:0] sck_s, mosi_s, csn_s;
  logic                   sck_d;
  logic [2:0]             bit_cnt;
  logic [6:0]             shreg;
  logic                   sck_rise, mosi_q;

  assign sck_rise = sck_s[SYNC_STAGES-1] & ~sck_d;
  assign mosi_q   = mosi_s[SYNC_STAGES-1];
  assign cs_idle  = csn_s[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s  <= '0;
      mosi_s <= '0;
      csn_s  <= '1;
      sck_d  <= 1'b0;
    end else begin
      sck_s  <= {sck_s[SYNC_STAGES-2:0], spi_sck};
      mosi_s <= {mosi_s[SYNC_STAGES-2:0], spi_mosi};
      csn_s  <= {csn_s[SYNC_STAGES-2:0], spi_cs_n};
      sck_d  <= sck_s[SYNC_STAGES-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      shreg     <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (cs_idle) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        shreg   <= {shreg[5:0], mosi_q};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_vld  <= 1'b1;
          byte_data <= {shreg, mosi_q};
        end
      end
    end
  end

endmodule

// File: rtl/led_pixel_pack.sv
module led_pixel_pack
  import ledstrip_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld,
  input  logic [7:0] byte_data,
  input  logic       cs_idle,
  input  logic       drop,
  output logic       pix_vld,
  output pixel_t     pix_data
);

  localparam int NBYTES = PIX_W / 8;
  localparam int BW     = $clog2(NBYTES);

  logic [BW-1:0]      idx;
  logic [PIX_W-9:0]   acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx      <= '0;
      acc      <= '0;
      pix_vld  <= 1'b0;
      pix_data <= '0;
    end else begin
      pix_vld <= 1'b0;
      if (cs_idle) begin
        idx <= '0;
      end else if (byte_vld && !drop) begin
        acc <= {acc[PIX_W-17:0], byte_data};
        if (idx == BW'(NBYTES-1)) begin
          idx      <= '0;
          pix_vld  <= 1'b1;
          pix_data <= {acc, byte_data};
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/led_frame_buf.sv
module led_frame_buf #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/led_bit_encoder.sv
module led_bit_encoder #(
  parameter int T0H   = 50,
  parameter int T0L   = 106,
  parameter int T1H   = 100,
  parameter int T1L   = 56,
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PIX_W-1:0] word,
  output logic             last,
  output logic             dout
);

  localparam int THI  = (T1H > T0H) ? T1H : T0H;
  localparam int TLO  = (T1L > T0L) ? T1L : T0L;
  localparam int TMAX = (THI > TLO) ? THI : TLO;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int IW   = $clog2(PIX_W);
  localparam logic [CW-1:0] H0 = CW'(T0H - 1);
  localparam logic [CW-1:0] H1 = CW'(T1H - 1);
  localparam logic [CW-1:0] L0 = CW'(T0L - 1);
  localparam logic [CW-1:0] L1 = CW'(T1L - 1);

  logic             active, in_high;
  logic [CW-1:0]    cnt;
  logic [PIX_W-1:0] sh;
  logic [IW-1:0]    idx;

  assign last = active & ~in_high & (cnt == '0) & (idx == IW'(PIX_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      in_high <= 1'b0;
      cnt     <= '0;
      sh      <= '0;
      idx     <= '0;
      dout    <= 1'b0;
    end else if (start && (!active || last)) begin
      active  <= 1'b1;
      in_high <= 1'b1;
      sh      <= word;
      idx     <= '0;
      cnt     <= word[PIX_W-1] ? H1 : H0;
      dout    <= 1'b1;
    end else if (active) begin
      if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else if (in_high) begin
        in_high <= 1'b0;
        dout    <= 1'b0;
        cnt     <= sh[PIX_W-1] ? L1 : L0;
      end else if (last) begin
        active <= 1'b0;
      end else begin
        sh      <= {sh[PIX_W-2:0], 1'b0};
        idx     <= idx + 1'b1;
        in_high <= 1'b1;
        dout    <= 1'b1;
        cnt     <= sh[PIX_W-2] ? H1 : H0;
      end
    end
  end

endmodule

// File: rtl/ledstrip_spi_driver.sv
module ledstrip_spi_driver
  import ledstrip_pkg::*;
#(
  parameter int CLK_HZ      = 125_000_000,
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_mosi,
  input  logic spi_cs_n,
  input  logic sync_in,
  output logic led_dout,
  output logic busy
);

  localparam int T0H       = ns_to_cycles(CLK_HZ, 400);
  localparam int T0L       = ns_to_cycles(CLK_HZ, 850);
  localparam int T1H       = ns_to_cycles(CLK_HZ, 800);
  localparam int T1L       = ns_to_cycles(CLK_HZ, 450);
  localparam int LATCH_CYC = ns_to_cycles(CLK_HZ, 50_000);
  localparam int LW        = $clog2(LATCH_CYC + 1);
  localparam int SL        = SYNC_STAGES + 3;

  logic         byte_vld, cs_idle, pix_vld, pix_acc;
  logic [7:0]   byte_data;
  pixel_t       pix_data, rdata;
  logic         enc_start, enc_last;

  tx_state_e        state;
  logic [ADDR_W:0]  wr_cnt, rd_ptr, frame_len, len_now;
  logic [LW-1:0]    lat_cnt;
  logic [SL-1:0]    sync_sh;
  logic             sync_go, lat_done;

  assign busy = (state != ST_IDLE);

  led_spi_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .byte_vld(byte_vld), .byte_data(byte_data),
    .cs_idle(cs_idle)
  );

  led_pixel_pack u_pack (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
    .cs_idle(cs_idle), .drop(busy), .pix_vld(pix_vld), .pix_data(pix_data)
  );

  // SYNC passes the same synchronizer depth as SCK, then waits out the
  // two register stages of byte and pixel assembly
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_sh <= '0;
    else        sync_sh <= {sync_sh[SL-2:0], sync_in};
  end
  assign sync_go = sync_sh[SYNC_STAGES+1] & ~sync_sh[SYNC_STAGES+2];

  assign pix_acc = pix_vld & ~busy & ~wr_cnt[ADDR_W];
  assign len_now = wr_cnt + {{ADDR_W{1'b0}}, pix_acc};

  led_frame_buf #(.ADDR_W(ADDR_W), .DATA_W(PIX_W)) u_buf (
    .clk(clk), .we(pix_acc), .waddr(wr_cnt[ADDR_W-1:0]), .wdata(pix_data),
    .raddr(rd_ptr[ADDR_W-1:0]), .rdata(rdata)
  );

  assign enc_start = (state == ST_LOAD) ||
                     (state == ST_SEND && enc_last && rd_ptr != frame_len);

  led_bit_encoder #(
    .T0H(T0H), .T0L(T0L), .T1H(T1H), .T1L(T1L), .PIX_W(PIX_W)
  ) u_enc (
    .clk(clk), .rst_n(rst_n), .start(enc_start), .word(rdata),
    .last(enc_last), .dout(led_dout)
  );

  assign lat_done = (state == ST_LATCH) && (lat_cnt == LW'(LATCH_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cnt <= '0;
    end else if (lat_done) begin
      wr_cnt <= '0;
    end else if (pix_acc) begin
      wr_cnt <= wr_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      rd_ptr    <= '0;
      frame_len <= '0;
      lat_cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (sync_go) begin
            frame_len <= len_now;
            rd_ptr    <= '0;
            lat_cnt   <= '0;
            state     <= (len_now == '0) ? ST_LATCH : ST_FETCH;
          end
        end
        ST_FETCH: state <= ST_LOAD;
        ST_LOAD: begin
          rd_ptr <= rd_ptr + 1'b1;
          state  <= ST_SEND;
        end
        ST_SEND: begin
          if (enc_last) begin
            if (rd_ptr == frame_len) begin
              lat_cnt <= '0;
              state   <= ST_LATCH;
            end else begin
              rd_ptr <= rd_ptr + 1'b1;
            end
          end
        end
        ST_LATCH: begin
          if (lat_done) state <= ST_IDLE;
          else          lat_cnt <= lat_cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ledstrip_checker.sv
module ledstrip_checker
  import ledstrip_pkg::*;
#(
  parameter int CLK_HZ = 125_000_000,
  parameter int ADDR_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            led_dout,
  input logic            busy,
  input logic [ADDR_W:0] wr_cnt
);

  localparam int T0H   = ns_to_cycles(CLK_HZ, 400);
  localparam int T0L   = ns_to_cycles(CLK_HZ, 850);
  localparam int T1H   = ns_to_cycles(CLK_HZ, 800);
  localparam int T1L   = ns_to_cycles(CLK_HZ, 450);
  localparam int LATCH = ns_to_cycles(CLK_HZ, 50_000);
  localparam int DEPTH = 1 << ADDR_W;

  logic [31:0] hi_run, lo_run;
  logic        in_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run   <= '0;
      lo_run   <= '0;
      in_frame <= 1'b0;
    end else begin
      hi_run <= led_dout ? hi_run + 32'd1 : 32'd0;
      if (led_dout)                     lo_run <= '0;
      else if (lo_run < 32'(LATCH + 1)) lo_run <= lo_run + 32'd1;
      if (!busy)          in_frame <= 1'b0;
      else if (!led_dout) in_frame <= in_frame | (hi_run != '0);
    end
  end

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !led_dout) else $error("idle output high"); // R12

  AST_HIGH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    led_dout |-> hi_run < 32'(T1H)) else $error("high too long"); // R4

  AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!led_dout && hi_run != '0) |-> (hi_run == 32'(T0H) || hi_run == 32'(T1H)))
    else $error("bad high width"); // R4

  AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (led_dout && hi_run == '0 && in_frame) |-> (lo_run == 32'(T0L) || lo_run == 32'(T1L)))
    else $error("bad low width"); // R4

  AST_LATCH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> lo_run >= 32'(LATCH)) else $error("latch gap short"); // R5

  AST_WR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> wr_cnt == '0) else $error("write address kept"); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt <= (ADDR_W+1)'(DEPTH)) else $error("buffer overrun"); // R10

endmodule

bind ledstrip_spi_driver ledstrip_checker #(.CLK_HZ(CLK_HZ), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .led_dout(led_dout), .busy(busy), .wr_cnt(wr_cnt)
);

// File: tb/ledstrip_spi_driver_bench.sv
`timescale 1ns/1ps
module ledstrip_spi_driver_bench;

  localparam int ADDR_W = 2;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int T0H    = 50;
  localparam int T0L    = 106;
  localparam int T1H    = 100;
  localparam int T1L    = 56;
  localparam int LATCH  = 6250;
  localparam int HALF   = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, cs_n = 1'b1, sync = 1'b0;
  logic dout, busy;

  int n_tests = 0, n_fail = 0;
  bit exp_q[$];

  always #4 clk = ~clk;

  ledstrip_spi_driver #(.CLK_HZ(125_000_000), .ADDR_W(ADDR_W)) u_ledstrip_spi_driver (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_mosi(mosi), .spi_cs_n(cs_n),
    .sync_in(sync), .led_dout(dout), .busy(busy)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: decodes pulses and pops expected bits
  logic prev_dout = 1'b0, prev_busy = 1'b0, last_bit = 1'b0, in_frame = 1'b0;
  int hi_len = 0, lo_len = 0, busy_len = 0, last_busy_len = 0, bits_seen = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (dout) begin
        if (!prev_dout) begin
          if (in_frame)
            check(lo_len == (last_bit ? T1L : T0L), "R4", "low width",
                  lo_len, last_bit ? T1L : T0L);
          hi_len = 1;
        end else hi_len++;
      end else begin
        if (prev_dout) begin
          bit b;
          check(hi_len == T0H || hi_len == T1H, "R4", "high width", hi_len, T0H);
          b = (hi_len == T1H);
          bits_seen++;
          if (exp_q.size() == 0) check(1'b0, "R3", "unexpected bit", int'(b), -1);
          else begin
            bit e;
            e = exp_q.pop_front();
            check(b == e, "R3", "bit value", int'(b), int'(e));
          end
          last_bit = b;
          in_frame = 1'b1;
          lo_len = 1;
        end else lo_len++;
      end
      if (busy) busy_len++;
      if (prev_busy && !busy) begin
        last_busy_len = busy_len;
        if (in_frame)
          check(lo_len >= LATCH && lo_len <= LATCH + T0L + 3, "R5", "latch gap",
                lo_len, LATCH + (last_bit ? T1L : T0L));
        in_frame = 1'b0;
      end
      if (!busy) busy_len = 0;
      prev_dout = dout;
      prev_busy = busy;
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic spi_bit(bit b, bit sync_too);
    mosi = b;
    wait_clk(HALF);
    sck = 1'b1;
    if (sync_too) sync = 1'b1;
    wait_clk(HALF);
    sck = 1'b0;
  endtask

  task automatic spi_pixel(logic [23:0] p, bit expected, bit sync_on_last);
    for (int i = 23; i >= 0; i--) begin
      spi_bit(p[i], sync_on_last && i == 0);
      if (expected) exp_q.push_back(p[i]);
    end
  endtask

  task automatic pulse_sync();
    sync = 1'b1;
    wait_clk(8);
    sync = 1'b0;
  endtask

  task automatic wait_done();
    while (busy) wait_clk(1);
    wait_clk(20);
  endtask

  int seen0;

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    // R12 reset state
    check(dout == 1'b0, "R12", "dout after reset", int'(dout), 0);
    check(busy == 1'b0, "R12", "busy after reset", int'(busy), 0);

    // R2 R3 R4 R6: three-pixel frame
    cs_n = 1'b0; wait_clk(4);
    spi_pixel(24'hA5C30F, 1, 0);
    spi_pixel(24'hFFFFFF, 1, 0);
    spi_pixel(24'h000001, 1, 0);
    cs_n = 1'b1; wait_clk(10);
    pulse_sync();
    check(busy == 1'b1, "R6", "busy after SYNC", int'(busy), 1);
    // R7: pixel and SYNC while busy are discarded
    cs_n = 1'b0; wait_clk(4);
    spi_pixel(24'h123456, 0, 0);
    cs_n = 1'b1;
    pulse_sync();
    wait_done();
    check(exp_q.size() == 0, "R3", "bits left in frame", exp_q.size(), 0);
    wait_clk(300);
    check(busy == 1'b0, "R7", "SYNC while busy restarted", int'(busy), 0);

    // R9 R8 R7: empty buffer gives only the latch gap
    seen0 = bits_seen;
    pulse_sync();
    wait_done();
    check(bits_seen == seen0, "R9", "bits on empty frame", bits_seen - seen0, 0);
    check(last_busy_len >= LATCH && last_busy_len <= LATCH + 2, "R9", "empty busy length",
          last_busy_len, LATCH);

    // R1: partial byte and partial pixel dropped by chip select
    cs_n = 1'b0; wait_clk(4);
    spi_bit(1, 0); spi_bit(0, 0); spi_bit(1, 0);
    cs_n = 1'b1; wait_clk(10);
    cs_n = 1'b0; wait_clk(4);
    for (int i = 7; i >= 0; i--) spi_bit(i[0], 0);
    cs_n = 1'b1; wait_clk(10);
    cs_n = 1'b0; wait_clk(4);
    spi_pixel(24'h5A0FF0, 1, 0);
    cs_n = 1'b1; wait_clk(10);
    seen0 = bits_seen;
    pulse_sync();
    wait_done();
    check(bits_seen - seen0 == 24, "R1", "bits after resync", bits_seen - seen0, 24);
    check(exp_q.size() == 0, "R1", "bits left after resync", exp_q.size(), 0);

    // R10: one pixel beyond capacity is dropped
    cs_n = 1'b0; wait_clk(4);
    for (int k = 0; k < DEPTH + 1; k++)
      spi_pixel(24'h010203 * (k + 1), k < DEPTH, 0);
    cs_n = 1'b1; wait_clk(10);
    seen0 = bits_seen;
    pulse_sync();
    wait_done();
    check(bits_seen - seen0 == 24 * DEPTH, "R10", "bits when full",
          bits_seen - seen0, 24 * DEPTH);
    check(exp_q.size() == 0, "R10", "bits left when full", exp_q.size(), 0);

    // R11: SYNC rises with the last SCK edge of the final pixel
    cs_n = 1'b0; wait_clk(4);
    spi_pixel(24'h800001, 1, 0);
    spi_pixel(24'h3C3C3C, 1, 1);
    wait_clk(12);
    sync = 1'b0;
    cs_n = 1'b1;
    seen0 = bits_seen;
    check(busy == 1'b1, "R11", "busy on coincident SYNC", int'(busy), 1);
    wait_done();
    check(bits_seen - seen0 == 48, "R11", "bits with coincident SYNC",
          bits_seen - seen0, 48);
    check(exp_q.size() == 0, "R11", "bits left with coincident SYNC", exp_q.size(), 0);
    check(dout == 1'b0, "R5", "dout after frame", int'(dout), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190_000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule